// File: doc/BRIEF.md
# Video Raster Sync Timing Generator

This block produces the raster timing for a video encoder pipeline. It runs from a clock at twice the pixel rate and makes its own pixel-rate enable by dividing that clock by two or by four. From programmable line and field geometry it keeps a pixel counter, a line counter and an odd/even field flag. From those it decodes horizontal sync, vertical sync, composite blanking and a three-way level code that tells a downstream output stage to emit front porch, blanking or active picture.

In master mode the counters run freely and the block is the timing source. In slave mode external horizontal and vertical sync pulses drive the raster. An early horizontal pulse cuts the line short. If the pulse is late, the line stretches at the front porch level until the pulse comes. Vertical sync works the same way at field level: an early pulse shortens the field, and a late one holds the raster at the blanking level. The active level of every sync, blanking and field pin can be set on its own. Geometry, mode and polarity inputs are captured while reset is held.

Top module: `vsg_timing_gen`

## Requirements
- R1: `pix_ce` is high for exactly one `clk2x` cycle in every 2 cycles when `div4`=0, and in every 4 cycles when `div4`=1.
- R2: While `rst` is high, `pix_ce` is 0. The first pixel emitted after reset has `pixel_cnt`=0 and `line_cnt`=0, and the field flag marks the odd field.
- R3: In master mode `pixel_cnt` counts 0 to `line_len`-1 and wraps to 0, and `line_cnt` advances at each wrap. After line `field_lines`-1, `line_cnt` returns to 0 and the field flag toggles.
- R4: Horizontal sync is active while `pixel_cnt` < `hsync_width`. Vertical sync is active while `line_cnt` < `vsync_lines`, except during a held field end. Blanking is active while `pixel_cnt` < `hblank_end`, while `line_cnt` < `vblank_lines`, or during any held line end or field end. Each pin level is the active flag XOR its `*_act_low` bit. `field_out` is (odd flag) XOR `field_act_low`, so it is 1 for odd fields when that bit is 0.
- R5: `level_sel` is 2'd0 (front porch) during a held line end, 2'd2 (active) when blanking is inactive, and 2'd1 (blanking) otherwise.
- R6: Slave mode: a horizontal sync pulse that arrives before `pixel_cnt` reaches `line_len`-1 returns `pixel_cnt` to 0 and advances `line_cnt`.
- R7: Slave mode: if no horizontal sync pulse has arrived when `pixel_cnt` reaches `line_len`-1, the counter holds there with `level_sel`=0 and blanking active until the pulse arrives. The next line then starts at pixel 0.
- R8: Slave mode: a vertical sync pulse that arrives before the programmed field end makes the next line start at `line_cnt`=0, which shortens the field.
- R9: Slave mode: if a line starts after line `field_lines`-1 with no vertical sync pending, `line_cnt` holds at `field_lines`-1, blanking stays active, `level_sel` is 2'd1 outside the porch hold, and vertical sync is inactive. This lasts until a vertical pulse arrives.
- R10: Slave mode: a vertical pulse that arrives together with a horizontal pulse starts an odd field. One that arrives mid-line starts an even field.
- R11: The active level of `hs_in` and `vs_in` is set by `hs_act_low` and `vs_act_low`. A pulse held active for several pixels acts only once.
- R12: In master mode `hs_in` and `vs_in` have no effect. Geometry, mode and polarity inputs are sampled only while `rst` is high, so changing them later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset; configuration is loaded while high |
| div4 | input | 1 | 1 selects divide-by-four pixel enable, 0 selects divide-by-two |
| slave_mode | input | 1 | 1 locks the raster to external sync pulses |
| hs_act_low | input | 1 | Horizontal sync pins are active-low when 1 |
| vs_act_low | input | 1 | Vertical sync pins are active-low when 1 |
| blank_act_low | input | 1 | Blanking pin is active-low when 1 |
| field_act_low | input | 1 | Inverts the field pin when 1 |
| line_len | input | HCW | Pixels per line |
| hsync_width | input | HCW | Horizontal sync width in pixels |
| hblank_end | input | HCW | First unblanked pixel of a line |
| field_lines | input | VCW | Lines per field |
| vsync_lines | input | VCW | Vertical sync length in lines |
| vblank_lines | input | VCW | Vertical blanking length in lines |
| hs_in | input | 1 | External horizontal sync (slave mode) |
| vs_in | input | 1 | External vertical sync (slave mode) |
| pix_ce | output | 1 | Pixel-rate enable |
| hs_out | output | 1 | Horizontal sync |
| vs_out | output | 1 | Vertical sync |
| blank_out | output | 1 | Composite blanking |
| field_out | output | 1 | Odd/even field indicator |
| pixel_cnt | output | HCW | Pixel position within the line |
| line_cnt | output | VCW | Line position within the field |
| level_sel | output | 2 | 0 front porch, 1 blanking, 2 active |

## Verification
The hardest state to reach is the held field end in slave mode. Getting there needs a full field of correctly timed horizontal pulses with vertical sync withheld, and the stretched line end must be held first on the way. The bench uses a small geometry with a line of twelve pixels and a field of five lines. It steps through lines with a task that waits for the line-end hold and then pulses horizontal sync. It then places vertical pulses either mid-line or in the same cycle as a horizontal pulse, to tell the two field-phase outcomes apart. Random master configurations toggle the sync pins and rewrite the geometry inputs during the run to show that both are ignored.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    LVL_PORCH  = 2'd0,
    LVL_BLANK  = 2'd1,
    LVL_ACTIVE = 2'd2
  } level_e;
endpackage

// File: rtl/vsg_clk_div.sv
module vsg_clk_div #(
  parameter int CW = 2
) (
  input  logic clk2x,
  input  logic rst,
  input  logic div4,
  output logic ce
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = div4 ? CW'(3) : CW'(1);
  assign ce   = (cnt == last);

  always_ff @(posedge clk2x) begin
    if (rst) cnt <= '0;
    else if (ce) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  // R1
  ce_single_chk: assert property (@(posedge clk2x) disable iff (rst) ce |=> !ce);
  // R1
  ce_div2_chk: assert property (@(posedge clk2x) disable iff (rst) (!div4 && !ce) |=> ce);
endmodule

// File: rtl/vsg_sync_in.sv
module vsg_sync_in (
  input  logic clk2x,
  input  logic rst,
  input  logic pin,
  input  logic act_low,
  output logic edge_p
);
  logic s1, s2, s3;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin ^ act_low;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_p = s2 & ~s3;

  // R11
  sync_edge_once_chk: assert property (@(posedge clk2x) disable iff (rst) edge_p |=> !edge_p);
endmodule

// File: rtl/vsg_raster.sv
module vsg_raster #(
  parameter int HCW = 11,
  parameter int VCW = 10
) (
  input  logic           clk2x,
  input  logic           rst,
  input  logic           ce,
  input  logic           slave,
  input  logic           hs_edge,
  input  logic           vs_edge,
  input  logic [HCW-1:0] cfg_len,
  input  logic [VCW-1:0] cfg_lines,
  output logic [HCW-1:0] h,
  output logic [VCW-1:0] v,
  output logic           odd,
  output logic           h_over,
  output logic           v_over
);
  logic hs_pend, vs_pend, vs_even;
  logic h_last, v_last;

  assign h_last = (h == cfg_len - HCW'(1));
  assign v_last = (v == cfg_lines - VCW'(1));

  always_ff @(posedge clk2x) begin
    if (rst) begin
      h       <= '0;
      v       <= '0;
      odd     <= 1'b1;
      h_over  <= 1'b0;
      v_over  <= 1'b0;
      hs_pend <= 1'b0;
      vs_pend <= 1'b0;
      vs_even <= 1'b0;
    end else begin
      hs_pend <= slave && (hs_edge || (hs_pend && !ce));
      vs_pend <= slave && (vs_edge || (vs_pend && !(ce && hs_pend)));
      if (ce) begin
        if (!slave) begin
          h_over <= 1'b0;
          v_over <= 1'b0;
          if (h_last) begin
            h <= '0;
            if (v_last) begin
              v   <= '0;
              odd <= ~odd;
            end else begin
              v <= v + VCW'(1);
            end
          end else begin
            h <= h + HCW'(1);
          end
        end else begin
          if (vs_pend && !hs_pend) vs_even <= 1'b1;
          if (hs_pend) begin
            h      <= '0;
            h_over <= 1'b0;
            if (vs_pend) begin
              v       <= '0;
              v_over  <= 1'b0;
              odd     <= ~vs_even;
              vs_even <= 1'b0;
            end else if (v_last) begin
              v_over <= 1'b1;
            end else begin
              v <= v + VCW'(1);
            end
          end else if (h_last) begin
            h_over <= 1'b1;
          end else begin
            h <= h + HCW'(1);
          end
        end
      end
    end
  end

  // R3
  h_range_chk: assert property (@(posedge clk2x) disable iff (rst) h <= cfg_len - HCW'(1));
  // R3
  master_wrap_chk: assert property (@(posedge clk2x) disable iff (rst)
    (ce && !slave && h_last) |=> (h == '0));
  // R6
  slave_restart_chk: assert property (@(posedge clk2x) disable iff (rst)
    (ce && slave && hs_pend) |=> (h == '0 && !h_over));
  // R7
  porch_hold_chk: assert property (@(posedge clk2x) disable iff (rst) h_over |-> h_last);
  // R9
  field_hold_chk: assert property (@(posedge clk2x) disable iff (rst) v_over |-> v_last);
endmodule

// File: rtl/vsg_timing_gen.sv
module vsg_timing_gen #(
  parameter int HCW = 11,
  parameter int VCW = 10
) (
  input  logic           clk2x,
  input  logic           rst,
  input  logic           div4,
  input  logic           slave_mode,
  input  logic           hs_act_low,
  input  logic           vs_act_low,
  input  logic           blank_act_low,
  input  logic           field_act_low,
  input  logic [HCW-1:0] line_len,
  input  logic [HCW-1:0] hsync_width,
  input  logic [HCW-1:0] hblank_end,
  input  logic [VCW-1:0] field_lines,
  input  logic [VCW-1:0] vsync_lines,
  input  logic [VCW-1:0] vblank_lines,
  input  logic           hs_in,
  input  logic           vs_in,
  output logic           pix_ce,
  output logic           hs_out,
  output logic           vs_out,
  output logic           blank_out,
  output logic           field_out,
  output logic [HCW-1:0] pixel_cnt,
  output logic [VCW-1:0] line_cnt,
  output logic [1:0]     level_sel
);
  import vsg_pkg::*;

  localparam int NSYNC = 2;

  logic           div4_q, slave_q, hpol_q, vpol_q, bpol_q, fpol_q;
  logic [HCW-1:0] len_q, hsw_q, hbe_q;
  logic [VCW-1:0] lines_q, vsw_q, vbe_q;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      div4_q  <= div4;
      slave_q <= slave_mode;
      hpol_q  <= hs_act_low;
      vpol_q  <= vs_act_low;
      bpol_q  <= blank_act_low;
      fpol_q  <= field_act_low;
      len_q   <= line_len;
      hsw_q   <= hsync_width;
      hbe_q   <= hblank_end;
      lines_q <= field_lines;
      vsw_q   <= vsync_lines;
      vbe_q   <= vblank_lines;
    end
  end

  logic ce;
  vsg_clk_div u_div (.clk2x(clk2x), .rst(rst), .div4(div4_q), .ce(ce));

  logic [NSYNC-1:0] pin_v, pol_v, edge_v;
  assign pin_v = {vs_in, hs_in};
  assign pol_v = {vpol_q, hpol_q};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    vsg_sync_in u_in (
      .clk2x  (clk2x),
      .rst    (rst),
      .pin    (pin_v[i]),
      .act_low(pol_v[i]),
      .edge_p (edge_v[i])
    );
  end

  logic [HCW-1:0] h;
  logic [VCW-1:0] v;
  logic           odd, h_over, v_over;

  vsg_raster #(.HCW(HCW), .VCW(VCW)) u_raster (
    .clk2x    (clk2x),
    .rst      (rst),
    .ce       (ce),
    .slave    (slave_q),
    .hs_edge  (edge_v[0]),
    .vs_edge  (edge_v[1]),
    .cfg_len  (len_q),
    .cfg_lines(lines_q),
    .h        (h),
    .v        (v),
    .odd      (odd),
    .h_over   (h_over),
    .v_over   (v_over)
  );

  logic   hs_a, vs_a, blank_a;
  level_e lvl;

  always_comb begin
    hs_a    = (h < hsw_q);
    vs_a    = !v_over && (v < vsw_q);
    blank_a = h_over || v_over || (h < hbe_q) || (v < vbe_q);
    if (h_over)       lvl = LVL_PORCH;
    else if (blank_a) lvl = LVL_BLANK;
    else              lvl = LVL_ACTIVE;
  end

  always_ff @(posedge clk2x) begin
    if (rst) begin
      pix_ce    <= 1'b0;
      hs_out    <= 1'b0;
      vs_out    <= 1'b0;
      blank_out <= 1'b0;
      field_out <= 1'b0;
      pixel_cnt <= '0;
      line_cnt  <= '0;
      level_sel <= LVL_BLANK;
    end else begin
      pix_ce    <= ce;
      hs_out    <= hs_a ^ hpol_q;
      vs_out    <= vs_a ^ vpol_q;
      blank_out <= blank_a ^ bpol_q;
      field_out <= odd ^ fpol_q;
      pixel_cnt <= h;
      line_cnt  <= v;
      level_sel <= lvl;
    end
  end

  // R5
  level_blank_chk: assert property (@(posedge clk2x) disable iff (rst)
    (level_sel == LVL_ACTIVE) |=> ($past(level_sel) != LVL_ACTIVE) || (level_sel != LVL_ACTIVE) || (blank_out == bpol_q));
  // R5
  porch_blank_chk: assert property (@(posedge clk2x) disable iff (rst)
    (!$past(rst) && level_sel == LVL_PORCH) |-> (blank_out == !bpol_q));
endmodule

// File: tb/vsg_timing_gen_bench.sv
`timescale 1ns/1ps
module vsg_timing_gen_bench;
  localparam int HCW = 11;
  localparam int VCW = 10;

  logic clk2x = 1'b0;
  logic rst = 1'b1;
  logic div4 = 1'b0, slave_mode = 1'b0;
  logic hs_act_low = 1'b0, vs_act_low = 1'b0, blank_act_low = 1'b0, field_act_low = 1'b0;
  logic [HCW-1:0] line_len = '0, hsync_width = '0, hblank_end = '0;
  logic [VCW-1:0] field_lines = '0, vsync_lines = '0, vblank_lines = '0;
  logic hs_in = 1'b0, vs_in = 1'b0;
  logic pix_ce, hs_out, vs_out, blank_out, field_out;
  logic [HCW-1:0] pixel_cnt;
  logic [VCW-1:0] line_cnt;
  logic [1:0] level_sel;

  always #2 clk2x = ~clk2x;

  vsg_timing_gen #(.HCW(HCW), .VCW(VCW)) u_vsg_timing_gen (
    .clk2x(clk2x), .rst(rst), .div4(div4), .slave_mode(slave_mode),
    .hs_act_low(hs_act_low), .vs_act_low(vs_act_low),
    .blank_act_low(blank_act_low), .field_act_low(field_act_low),
    .line_len(line_len), .hsync_width(hsync_width), .hblank_end(hblank_end),
    .field_lines(field_lines), .vsync_lines(vsync_lines), .vblank_lines(vblank_lines),
    .hs_in(hs_in), .vs_in(vs_in),
    .pix_ce(pix_ce), .hs_out(hs_out), .vs_out(vs_out), .blank_out(blank_out),
    .field_out(field_out), .pixel_cnt(pixel_cnt), .line_cnt(line_cnt), .level_sel(level_sel)
  );

  int n_chk = 0, n_fail = 0;
  int c_len, c_hsw, c_hbe, c_lines, c_vsl, c_vbe;
  bit c_div4, c_hp, c_vp, c_bp, c_fp;
  int s_h, s_v, s_lvl;
  bit s_hs, s_vs, s_bl, s_f;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic get_sample();
    do @(negedge clk2x); while (!pix_ce);
    s_h = int'(pixel_cnt); s_v = int'(line_cnt); s_lvl = int'(level_sel);
    s_hs = hs_out; s_vs = vs_out; s_bl = blank_out; s_f = field_out;
  endtask

  task automatic do_reset(input bit slave);
    @(negedge clk2x);
    rst = 1'b1;
    slave_mode = slave; div4 = c_div4;
    hs_act_low = c_hp; vs_act_low = c_vp; blank_act_low = c_bp; field_act_low = c_fp;
    line_len = HCW'(c_len); hsync_width = HCW'(c_hsw); hblank_end = HCW'(c_hbe);
    field_lines = VCW'(c_lines); vsync_lines = VCW'(c_vsl); vblank_lines = VCW'(c_vbe);
    hs_in = c_hp; vs_in = c_vp;
    repeat (4) @(negedge clk2x);
    chk(pix_ce == 1'b0, "R2 ce low in reset", int'(pix_ce), 0);
    rst = 1'b0;
  endtask

  task automatic pulse(input bit do_h, input bit do_v);
    fork
      begin
        if (do_h) hs_in = ~c_hp;
        if (do_v) vs_in = ~c_vp;
        repeat (6) @(negedge clk2x);
        hs_in = c_hp;
        vs_in = c_vp;
      end
    join_none
  endtask

  task automatic wait_h(input int target, input int lim, output bit found);
    found = 1'b0;
    for (int k = 0; k < lim && !found; k++) begin
      get_sample();
      if (s_h == target) found = 1'b1;
    end
  endtask

  task automatic dec_chk(input int h, input int v, input bit odd);
    bit bl;
    int e_lvl;
    bl = (h < c_hbe) || (v < c_vbe);
    e_lvl = bl ? 1 : 2;
    chk(s_hs == ((h < c_hsw) ^ c_hp), "R4 hsync", int'(s_hs), int'((h < c_hsw) ^ c_hp));
    chk(s_vs == ((v < c_vsl) ^ c_vp), "R4 vsync", int'(s_vs), int'((v < c_vsl) ^ c_vp));
    chk(s_bl == (bl ^ c_bp), "R4 blank", int'(s_bl), int'(bl ^ c_bp));
    chk(s_f == (odd ^ c_fp), "R4 field pin", int'(s_f), int'(odd ^ c_fp));
    chk(s_lvl == e_lvl, "R5 level", s_lvl, e_lvl);
  endtask

  task automatic run_master(input int n);
    int m_h, m_v;
    bit m_odd;
    m_h = 0; m_v = 0; m_odd = 1'b1;
    for (int i = 0; i < n; i++) begin
      get_sample();
      if (i == 0) begin
        chk(s_h == 0 && s_v == 0, "R2 first pixel", s_h + s_v, 0);
        chk(s_f == (1'b1 ^ c_fp), "R2 odd field", int'(s_f), int'(1'b1 ^ c_fp));
        line_len = HCW'(c_len + 3); field_lines = VCW'(c_lines + 2);
        hsync_width = '0; div4 = ~c_div4; slave_mode = 1'b1;
      end
      if (i % 9 == 3) pulse(1'b1, i % 18 == 3);
      chk(s_h == m_h, "R3 R12 pixel count", s_h, m_h);
      chk(s_v == m_v, "R3 R12 line count", s_v, m_v);
      dec_chk(m_h, m_v, m_odd);
      if (m_h == c_len - 1) begin
        m_h = 0;
        if (m_v == c_lines - 1) begin m_v = 0; m_odd = ~m_odd; end
        else m_v++;
      end else m_h++;
    end
  endtask

  task automatic check_ce();
    int gap;
    get_sample();
    for (int k = 0; k < 6; k++) begin
      gap = 0;
      do begin @(negedge clk2x); gap++; end while (!pix_ce);
      chk(gap == (c_div4 ? 4 : 2), "R1 ce spacing", gap, c_div4 ? 4 : 2);
    end
  endtask

  task automatic slave_line();
    bit f;
    wait_h(c_len - 1, 40, f);
    pulse(1'b1, 1'b0);
    wait_h(0, 12, f);
  endtask

  initial begin
    bit f;
    void'($urandom(32'd4711));
    for (int cfg = 0; cfg < 4; cfg++) begin
      c_len = 8 + int'($urandom % 24);
      c_hsw = 1 + int'($urandom % 3);
      c_hbe = c_hsw + 1 + int'($urandom % 3);
      c_lines = 3 + int'($urandom % 6);
      c_vsl = 1;
      c_vbe = 1 + int'($urandom % 2);
      c_div4 = (cfg == 1) ? 1'b1 : (cfg == 2) ? 1'b0 : 1'($urandom);
      c_hp = 1'($urandom); c_vp = 1'($urandom); c_bp = 1'($urandom); c_fp = 1'($urandom);
      do_reset(1'b0);
      run_master(2 * c_len * c_lines + 5);
      check_ce();
    end

    // Slave mode, active-low pins, small geometry
    c_len = 12; c_hsw = 2; c_hbe = 3; c_lines = 5; c_vsl = 1; c_vbe = 2;
    c_div4 = 1'b0; c_hp = 1'b1; c_vp = 1'b1; c_bp = 1'b1; c_fp = 1'b0;
    do_reset(1'b1);
    get_sample();
    chk(s_h == 0 && s_v == 0, "R2 slave first pixel", s_h + s_v, 0);
    chk(s_f == 1'b1, "R2 slave odd field", int'(s_f), 1);

    // R7 late horizontal sync: hold at line end at front porch
    wait_h(c_len - 1, 40, f);
    chk(f, "R7 reached line end", int'(f), 1);
    for (int k = 0; k < 4; k++) begin
      get_sample();
      chk(s_h == c_len - 1, "R7 pixel held", s_h, c_len - 1);
      chk(s_lvl == 0, "R7 level porch", s_lvl, 0);
      chk(s_bl == 1'b0, "R7 blank active (low)", int'(s_bl), 0);
      chk(s_v == 0, "R7 line held", s_v, 0);
    end
    pulse(1'b1, 1'b0);
    f = 1'b0;
    for (int k = 0; k < 12 && !f; k++) begin get_sample(); f = (s_h != c_len - 1); end
    chk(s_h == 0, "R7 new line at pixel 0", s_h, 0);
    chk(s_v == 1, "R7 line advanced", s_v, 1);
    // R11 a long active pulse acts once
    for (int k = 1; k <= 3; k++) begin
      get_sample();
      chk(s_h == k, "R11 single restart", s_h, k);
    end

    // R6 early horizontal sync
    wait_h(6, 20, f);
    pulse(1'b1, 1'b0);
    f = 1'b0;
    for (int k = 0; k < 12 && !f; k++) begin get_sample(); f = (s_h == 0) || (s_h == c_len - 1); end
    chk(s_h == 0, "R6 line cut short", s_h, 0);
    chk(s_v == 2, "R6 line advanced", s_v, 2);
    wait_h(4, 20, f);
    chk(s_lvl == 2, "R5 active level", s_lvl, 2);
    chk(s_bl == 1'b1, "R5 blank inactive (high)", int'(s_bl), 1);

    // R8 early vertical sync mid-line, R10 even field
    slave_line();
    chk(s_v == 3, "R8 line before vsync", s_v, 3);
    wait_h(5, 20, f);
    pulse(1'b0, 1'b1);
    slave_line();
    chk(s_v == 0, "R8 field shortened", s_v, 0);
    chk(s_f == 1'b0, "R10 mid-line vsync gives even", int'(s_f), 0);

    // R9 late vertical sync: hold at last line at blanking
    for (int k = 0; k < 4; k++) slave_line();
    chk(s_v == c_lines - 1, "R9 last line reached", s_v, c_lines - 1);
    slave_line();
    chk(s_v == c_lines - 1, "R9 line held", s_v, c_lines - 1);
    wait_h(c_hbe + 1, 20, f);
    chk(s_lvl == 1, "R9 level blanking", s_lvl, 1);
    chk(s_bl == 1'b0, "R9 blank active (low)", int'(s_bl), 0);
    chk(s_vs == 1'b1, "R9 vsync inactive (high)", int'(s_vs), 1);
    slave_line();
    chk(s_v == c_lines - 1, "R9 still held", s_v, c_lines - 1);

    // R10 vertical sync coincident with horizontal sync gives odd field
    wait_h(c_len - 1, 40, f);
    pulse(1'b1, 1'b1);
    wait_h(0, 12, f);
    chk(s_v == 0, "R10 field restart", s_v, 0);
    chk(s_f == 1'b1, "R10 aligned vsync gives odd", int'(s_f), 1);
    get_sample();
    chk(s_vs == 1'b0, "R4 R11 vsync active-low on line 0", int'(s_vs), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk2x);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule